// File: doc/BRIEF.md
# Processor Status Register Unit

This block holds the eight-bit status byte of a small single-issue RISC core. Each cycle it can take flag results from the ALU, one enable per flag, so an operation updates only the flags it defines. It also keeps the global interrupt enable. That bit is cleared by hardware when an interrupt is accepted and set again by the return-from-interrupt strobe. No other bit is saved or restored on that path.

A dedicated transfer bit T moves single bits between the core's register operands and the status byte. A bit-store command copies a selected bit of an operand byte into T. The bit-load output gives the operand byte with the selected bit replaced by T. This output is combinational, so the core can write it back in the same cycle.

The whole byte is readable at all times on the status output and writable through the core's I/O port at address 0x3F. The sign flag never takes a written or computed value of its own: it is always the exclusive-or of the negative and overflow flags that are stored in the same cycle.

Top module: `psr_unit`

## Requirements
- R1: After reset every bit of the status byte is 0.
- R2: The status byte is laid out from bit 7 down to bit 0 as I, T, H, S, V, N, Z, C. Writing 0xFF through the I/O port gives 0xEF, and writing 0x10 gives 0x00.
- R3: In every cycle S (bit 4) equals N (bit 2) xor V (bit 3). This also holds after ALU updates and I/O writes.
- R4: The ALU enable and value vectors are 5 bits wide, ordered H, V, N, Z, C from bit 4 down to bit 0. A flag whose enable is 1 takes its value at the next clock edge. A flag whose enable is 0 keeps its value.
- R5: An I/O write with address 0x3F loads the byte, with S recomputed. An I/O write to any other address leaves the status byte unchanged.
- R6: When an I/O write at 0x3F and an ALU flag update happen in the same cycle, the written byte wins for every flag.
- R7: An interrupt acknowledge makes I 0 after the next clock edge. It wins over a return strobe and over an I/O write in the same cycle.
- R8: A return strobe without an acknowledge sets I to 1. If an I/O write at 0x3F happens in the same cycle, the written I is used instead.
- R9: A bit-store copies bit xfer_idx (3 bits, 0 to 7) of xfer_opnd into T at the next clock edge. An I/O write at 0x3F in the same cycle wins.
- R10: bld_byte equals xfer_opnd with bit xfer_idx replaced by the current T, in the same cycle. All other bits pass through unchanged.
- R11: An acknowledge or return strobe on its own changes only I. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_we | input | 5 | Per-flag update enables {H,V,N,Z,C} |
| alu_val | input | 5 | Per-flag new values {H,V,N,Z,C} |
| irq_ack | input | 1 | Interrupt accepted strobe, clears I |
| irq_ret | input | 1 | Return-from-interrupt strobe, sets I |
| bst_en | input | 1 | Bit-store command: T takes the selected operand bit |
| xfer_idx | input | 3 | Bit position for bit-store and bit-load |
| xfer_opnd | input | 8 | Register operand byte for bit transfers |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | 6 | I/O address |
| io_wdata | input | 8 | I/O write data |
| status | output | 8 | Current status byte {I,T,H,S,V,N,Z,C} |
| bld_byte | output | 8 | Operand byte with the selected bit replaced by T |

## Verification
Some properties are checked by assertions on every cycle after reset. These are the sign relation, I being cleared after an acknowledge, I being set after a lone return, T following a bit-store, untouched flags holding their value, and the other seven bits holding while an acknowledge is taken. Other behaviours can only be shown by the bench's scenarios. These are the exact byte produced by I/O writes, writes to other addresses being ignored, the winner of each collision, and the bit-load result for every position and T value. A reference model in the bench checks them under random and directed stimulus.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int PSR_W  = 8;
    localparam int IDX_W  = $clog2(PSR_W);
    localparam int FLAG_N = 5;

    // Field order is architectural: MSB first I,T,H,S,V,N,Z,C
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } psr_t;

    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/psr_flag_merge.sv
module psr_flag_merge
    import psr_pkg::*;
(
    input  logic [FLAG_N-1:0] cur_flags,
    input  logic [FLAG_N-1:0] upd_en,
    input  logic [FLAG_N-1:0] upd_val,
    output logic [FLAG_N-1:0] nxt_flags
);
    for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
        assign nxt_flags[k] = upd_en[k] ? upd_val[k] : cur_flags[k];
    end
endmodule

// File: rtl/psr_bit_xfer.sv
module psr_bit_xfer
    import psr_pkg::*;
(
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [PSR_W-1:0] opnd,
    input  logic             t_cur,
    output logic             picked_bit,
    output logic [PSR_W-1:0] loaded_byte
);
    assign picked_bit = opnd[sel_idx];

    for (genvar k = 0; k < PSR_W; k++) begin : g_ins
        assign loaded_byte[k] = (sel_idx == IDX_W'(k)) ? t_cur : opnd[k];
    end
endmodule

// File: rtl/psr_irq_ctrl.sv
module psr_irq_ctrl (
    input  logic cur_i,
    input  logic ack,
    input  logic ret,
    input  logic io_hit,
    input  logic io_i,
    output logic nxt_i
);
    // priority: acknowledge, then I/O write, then return
    always_comb begin
        nxt_i = cur_i;
        if (ret)    nxt_i = 1'b1;
        if (io_hit) nxt_i = io_i;
        if (ack)    nxt_i = 1'b0;
    end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int          IO_AW   = 6,
    parameter logic [IO_AW-1:0] PSR_ADR = IO_AW'(6'h3F)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLAG_N-1:0]   alu_we,
    input  logic [FLAG_N-1:0]   alu_val,
    input  logic                irq_ack,
    input  logic                irq_ret,
    input  logic                bst_en,
    input  logic [IDX_W-1:0]    xfer_idx,
    input  logic [PSR_W-1:0]    xfer_opnd,
    input  logic                io_we,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic [PSR_W-1:0]    io_wdata,
    output logic [PSR_W-1:0]    status,
    output logic [PSR_W-1:0]    bld_byte
);

    psr_t       psr_q, psr_d;
    psr_t       io_w;
    alu_flags_t cur_f, alu_f;
    logic       io_hit;
    logic       t_pick;
    logic       i_nxt;

    assign io_w   = psr_t'(io_wdata);
    assign io_hit = io_we && (io_addr == PSR_ADR);
    assign cur_f  = '{h: psr_q.h, v: psr_q.v, n: psr_q.n, z: psr_q.z, c: psr_q.c};

    psr_flag_merge i_merge (
        .cur_flags (cur_f),
        .upd_en    (alu_we),
        .upd_val   (alu_val),
        .nxt_flags (alu_f)
    );

    psr_bit_xfer i_xfer (
        .sel_idx     (xfer_idx),
        .opnd        (xfer_opnd),
        .t_cur       (psr_q.t),
        .picked_bit  (t_pick),
        .loaded_byte (bld_byte)
    );

    psr_irq_ctrl i_irq (
        .cur_i  (psr_q.i),
        .ack    (irq_ack),
        .ret    (irq_ret),
        .io_hit (io_hit),
        .io_i   (io_w.i),
        .nxt_i  (i_nxt)
    );

    always_comb begin
        psr_d   = psr_q;
        psr_d.h = alu_f.h;
        psr_d.v = alu_f.v;
        psr_d.n = alu_f.n;
        psr_d.z = alu_f.z;
        psr_d.c = alu_f.c;
        if (bst_en) psr_d.t = t_pick;
        if (io_hit) psr_d = io_w;
        psr_d.i = i_nxt;
        psr_d.s = psr_d.n ^ psr_d.v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psr_q <= '0;
        else        psr_q <= psr_d;
    end

    assign status = psr_q;

    // R3
    sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] == (status[3] ^ status[2]));

    // R7
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !status[7]);

    // R8
    ret_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && !io_hit) |=> status[7]);

    // R9
    bst_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !io_hit) |=> status[6] == $past(xfer_opnd[xfer_idx]));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_hit && alu_we == '0) |=> $stable({status[5], status[3:0]}));

    // R11
    irq_only_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || irq_ret) && !io_hit && !bst_en && alu_we == '0)
            |=> $stable(status[6:0]));

endmodule

// File: tb/test_psr_unit.sv
module test_psr_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] alu_we = '0, alu_val = '0;
    logic       irq_ack = 1'b0, irq_ret = 1'b0, bst_en = 1'b0;
    logic [2:0] xfer_idx = '0;
    logic [7:0] xfer_opnd = '0;
    logic       io_we = 1'b0;
    logic [5:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] status, bld_byte;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q = '0;

    always #2 clk = ~clk;

    psr_unit i_psr_unit (
        .clk, .rst_n, .alu_we, .alu_val, .irq_ack, .irq_ret, .bst_en,
        .xfer_idx, .xfer_opnd, .io_we, .io_addr, .io_wdata, .status, .bld_byte
    );

    function automatic logic [7:0] model_next(
        input logic [7:0] old, input logic [4:0] we, input logic [4:0] val,
        input logic ack, input logic ret, input logic bst, input logic [2:0] idx,
        input logic [7:0] opnd, input logic iowe, input logic [5:0] adr,
        input logic [7:0] wd);
        logic [7:0] r;
        r = old;
        if (we[4]) r[5] = val[4];
        if (we[3]) r[3] = val[3];
        if (we[2]) r[2] = val[2];
        if (we[1]) r[1] = val[1];
        if (we[0]) r[0] = val[0];
        if (bst) r[6] = opnd[idx];
        if (ret) r[7] = 1'b1;
        if (iowe && adr == 6'h3F) r = wd;
        if (ack) r[7] = 1'b0;
        r[4] = r[3] ^ r[2];
        return r;
    endfunction

    function automatic logic [7:0] model_bld(input logic [7:0] opnd,
                                             input logic [2:0] idx, input logic t);
        logic [7:0] r;
        r = opnd;
        r[idx] = t;
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [4:0] we, input logic [4:0] val,
                        input logic ack, input logic ret, input logic bst,
                        input logic [2:0] idx, input logic [7:0] opnd,
                        input logic iowe, input logic [5:0] adr, input logic [7:0] wd);
        @(negedge clk);
        alu_we = we; alu_val = val; irq_ack = ack; irq_ret = ret; bst_en = bst;
        xfer_idx = idx; xfer_opnd = opnd; io_we = iowe; io_addr = adr; io_wdata = wd;
        #1;
        check("R10 bld", bld_byte, model_bld(opnd, idx, exp_q[6]));
        exp_q = model_next(exp_q, we, val, ack, ret, bst, idx, opnd, iowe, adr, wd);
        @(posedge clk);
        #1;
        check(req, status, exp_q);
    endtask

    task automatic idle(input string req);
        step(req, 5'b0, 5'b0, 0, 0, 0, 3'd0, 8'h00, 0, 6'h00, 8'h00);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset", status, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", status, 8'h00);

        // R2 layout and sign override
        step("R2 write FF", 0, 0, 0, 0, 0, 0, 0, 1, 6'h3F, 8'hFF);
        step("R2 write 10", 0, 0, 0, 0, 0, 0, 0, 1, 6'h3F, 8'h10);
        // R5 other address ignored
        step("R5 setup", 0, 0, 0, 0, 0, 0, 0, 1, 6'h3F, 8'h65);
        step("R5 other addr", 0, 0, 0, 0, 0, 0, 0, 1, 6'h3E, 8'h9A);
        // R6 io beats ALU
        step("R6 io vs alu", 5'h1F, 5'h1F, 0, 0, 0, 0, 0, 1, 6'h3F, 8'h00);
        // R4 single flag updates
        step("R4 set C", 5'b00001, 5'b00001, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R4 set V only", 5'b01000, 5'b11111, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R4 H no enable", 5'b00000, 5'b10000, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8 return sets I, R11 others untouched
        step("R8 R11 ret", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R7 ack clears, R11
        step("R7 R11 ack", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R8 ret again", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R7 ack and ret", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R7 ack vs io", 0, 0, 1, 0, 0, 0, 0, 1, 6'h3F, 8'h80);
        step("R8 io vs ret", 0, 0, 0, 1, 0, 0, 0, 1, 6'h3F, 8'h00);
        // R9 io beats bit-store
        step("R9 io vs bst", 0, 0, 0, 0, 1, 3'd0, 8'hFF, 1, 6'h3F, 8'h00);

        // R9 R10 round trip of every bit position
        for (int k = 0; k < 8; k++) begin
            for (int b = 0; b < 2; b++) begin
                logic [7:0] op;
                op = 8'($urandom());
                op[k] = b[0];
                step("R9 bst", 0, 0, 0, 0, 1, 3'(k), op, 0, 0, 0);
                step("R10 bld path", 0, 0, 0, 0, 0, 3'(k), ~op, 0, 0, 0);
            end
        end

        // random mix, R3 R4 R5 R6 R7 R8 R9 R10
        for (int n = 0; n < 1500; n++) begin
            logic [5:0] adr;
            adr = ($urandom() % 2) ? 6'h3F : 6'($urandom());
            step("R3 random", 5'($urandom()), 5'($urandom()),
                 ($urandom() % 8) == 0, ($urandom() % 8) == 0, ($urandom() % 4) == 0,
                 3'($urandom()), 8'($urandom()), ($urandom() % 4) == 0, adr,
                 8'($urandom()));
        end
        idle("R4 idle hold");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule